// File: doc/BRIEF.md
# Split Non-Posted Request Queue with Reserved Legacy Slots

This block buffers downstream non-posted requests inside a chain device that also hosts a legacy ISA/LPC bridge. Each incoming request carries a one-bit destination flag. Requests flagged for the legacy bridge are held in a small reserved buffer. That buffer is sized to the number of legacy requests the host has agreed never to exceed. Every other request goes to a separate general FIFO. That FIFO feeds the forward path toward devices further down the chain or elsewhere in the same node.

The two buffers drain on their own valid/ready handshakes. A legacy bridge can stop taking requests while it waits for the answer to its own DMA read. When that happens, only the reserved buffer fills. Peer and pass-through traffic keeps flowing on the forward output, so the shared non-posted channel can never be clogged by the stalled legacy side. Requests may leave the two outputs in any relative order. If the host offers a legacy request while the reserved buffer is full, it has broken the agreed limit. The block then refuses the request and sets a sticky error flag.

Top module: `legacy_split_reqq`

## Requirements
- R1: A request accepted with `in_legacy`=1 appears only on the legacy output; a request accepted with `in_legacy`=0 appears only on the forward output.
- R2: The reserved buffer holds up to LEG_SLOTS requests (default 1). `in_ready` is high for a legacy request whenever fewer than LEG_SLOTS legacy requests are held.
- R3: `in_ready` depends only on the buffer named by `in_legacy`. A forward request is accepted while the reserved buffer is full and stalled, provided the general FIFO has room.
- R4: The general FIFO holds up to GEN_DEPTH requests. It delivers them on `fwd_data` in arrival order, and `in_ready` is low for forward requests when it is full.
- R5: The legacy output presents the oldest held legacy request. It removes that request only in a cycle with `leg_valid`=1 and `leg_ready`=1, and `leg_data` stays unchanged while stalled.
- R6: The forward output removes its head only in a cycle with `fwd_valid`=1 and `fwd_ready`=1, and `fwd_data` stays unchanged while stalled.
- R7: If `in_valid`=1 and `in_legacy`=1 at a clock edge while the reserved buffer is full, the request is not accepted and `ovf_err` is 1 from the next cycle. It then stays 1 until reset.
- R8: While `rst_n` is low at a clock edge, both buffers are emptied and `ovf_err` is cleared. After release, `leg_valid`=0, `fwd_valid`=0 and `ovf_err`=0.
- R9: The forward output keeps delivering and accepting requests while the legacy output is held with `leg_ready`=0, so the two outputs drain in any relative order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Incoming request present |
| in_legacy | input | 1 | 1: request targets the legacy bridge; 0: forward path |
| in_data | input | DATA_W | Request payload |
| in_ready | output | 1 | Request accepted at this edge if `in_valid` is high |
| leg_valid | output | 1 | Reserved buffer has a request for the legacy bridge |
| leg_ready | input | 1 | Legacy bridge takes the presented request |
| leg_data | output | DATA_W | Oldest reserved request |
| fwd_valid | output | 1 | General FIFO has a request for the forward path |
| fwd_ready | input | 1 | Forward path takes the presented request |
| fwd_data | output | DATA_W | Oldest general request |
| ovf_err | output | 1 | Sticky: host offered more legacy requests than reserved |

## Verification
The bench builds the block with LEG_SLOTS=2, GEN_DEPTH=4 and DATA_W=16. Two reserved slots use the ring variant of the buffer, which exposes oldest-first ordering within the legacy side. A four-entry general FIFO reaches full, wrap-around and simultaneous push/pop within a few cycles. With these sizes, long random runs repeatedly hit the case of a full and stalled reserved buffer beside a moving forward stream. A directed phase then exceeds the legacy limit to reach the sticky overflow flag, and a final reset clears it.

// File: rtl/reqq_pkg.sv
// Shared types for the split request queue.
// Assumes: a single destination bit chooses between the two buffers.
package reqq_pkg;
    typedef enum logic {
        DEST_FWD = 1'b0,
        DEST_LEG = 1'b1
    } reqq_dest_e;
endpackage

// File: rtl/reqq_fifo.sv
// Synchronous FIFO used for both the reserved legacy buffer and the general queue.
// A one-entry depth builds a single holding register; larger depths build a ring.
// Assumes: push is only asserted when not full, pop only when not empty.
module reqq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] count;

    // Occupancy counter: up on push, down on pop, unchanged on both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push && !pop) begin
            count <= count + 1'b1;
        end else if (pop && !push) begin
            count <= count - 1'b1;
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    generate
        if (DEPTH == 1) begin : g_single
            logic [W-1:0] hold_q;

            // Capture the lone entry on push.
            always_ff @(posedge clk) begin
                if (push) begin
                    hold_q <= push_data;
                end
            end

            assign pop_data = hold_q;
        end else begin : g_ring
            localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

            logic [W-1:0]  mem [DEPTH];
            logic [AW-1:0] wr_ptr;
            logic [AW-1:0] rd_ptr;

            // Advance write and read pointers with wrap at the last slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wr_ptr <= '0;
                    rd_ptr <= '0;
                end else begin
                    if (push) begin
                        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                    end
                    if (pop) begin
                        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
                    end
                end
            end

            // Store the pushed payload at the write pointer.
            always_ff @(posedge clk) begin
                if (push) begin
                    mem[wr_ptr] <= push_data;
                end
            end

            assign pop_data = mem[rd_ptr];
        end
    endgenerate
endmodule

// File: rtl/reqq_steer.sv
// Input steering: picks the buffer named by the destination flag, derives the
// input ready from that buffer alone, and keeps the sticky overflow flag.
// Assumes: the host never offers more legacy requests than reserved slots.
module reqq_steer
    import reqq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_legacy,
    input  logic leg_full,
    input  logic gen_full,
    output logic in_ready,
    output logic leg_push,
    output logic gen_push,
    output logic ovf_err
);
    reqq_dest_e dest;
    logic       ovf_q;

    // Decode the destination of the current request.
    always_comb begin
        dest = in_legacy ? DEST_LEG : DEST_FWD;
    end

    // Ready follows only the selected buffer's fullness.
    always_comb begin
        case (dest)
            DEST_LEG: in_ready = !leg_full;
            default:  in_ready = !gen_full;
        endcase
    end

    assign leg_push = in_valid && in_ready && (dest == DEST_LEG);
    assign gen_push = in_valid && in_ready && (dest == DEST_FWD);

    // Latch an overflow when a legacy request meets a full reserved buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (in_valid && (dest == DEST_LEG) && leg_full) begin
            ovf_q <= 1'b1;
        end
    end

    assign ovf_err = ovf_q;
endmodule

// File: rtl/legacy_split_reqq.sv
// Downstream non-posted request queue with a reserved buffer for the legacy
// bridge and a separate general FIFO for all other destinations.
// Assumes: LEG_SLOTS equals the host's agreed legacy request limit.
module legacy_split_reqq #(
    parameter int DATA_W    = 32,
    parameter int LEG_SLOTS = 1,
    parameter int GEN_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_legacy,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              leg_valid,
    input  logic              leg_ready,
    output logic [DATA_W-1:0] leg_data,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [DATA_W-1:0] fwd_data,
    output logic              ovf_err
);
    logic leg_push, gen_push;
    logic leg_full, gen_full;
    logic leg_empty, gen_empty;
    logic leg_pop, gen_pop;

    reqq_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_legacy (in_legacy),
        .leg_full  (leg_full),
        .gen_full  (gen_full),
        .in_ready  (in_ready),
        .leg_push  (leg_push),
        .gen_push  (gen_push),
        .ovf_err   (ovf_err)
    );

    reqq_fifo #(.W(DATA_W), .DEPTH(LEG_SLOTS)) u_leg_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (leg_push),
        .push_data (in_data),
        .pop       (leg_pop),
        .pop_data  (leg_data),
        .full      (leg_full),
        .empty     (leg_empty)
    );

    reqq_fifo #(.W(DATA_W), .DEPTH(GEN_DEPTH)) u_gen_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (gen_push),
        .push_data (in_data),
        .pop       (gen_pop),
        .pop_data  (fwd_data),
        .full      (gen_full),
        .empty     (gen_empty)
    );

    assign leg_valid = !leg_empty;
    assign fwd_valid = !gen_empty;
    assign leg_pop   = leg_valid && leg_ready;
    assign gen_pop   = fwd_valid && fwd_ready;
endmodule

// File: rtl/legacy_split_reqq_checker.sv
// Port-level properties of the split request queue, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module legacy_split_reqq_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_legacy,
    input logic              in_ready,
    input logic              leg_valid,
    input logic              leg_ready,
    input logic [DATA_W-1:0] leg_data,
    input logic              fwd_valid,
    input logic              fwd_ready,
    input logic [DATA_W-1:0] fwd_data,
    input logic              ovf_err
);
    a_r8_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!leg_valid && !fwd_valid && !ovf_err));

    a_r3_fwd_accept_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_legacy && !fwd_valid) |-> in_ready);

    a_r2_leg_accept_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legacy && !leg_valid) |-> in_ready);

    a_r1_leg_not_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_legacy && !fwd_valid) |=> !fwd_valid);

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legacy && !in_ready) |=> ovf_err);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    a_r5_leg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_valid && !leg_ready) |=> (leg_valid && $stable(leg_data)));

    a_r6_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data)));
endmodule

bind legacy_split_reqq legacy_split_reqq_checker #(.DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_legacy (in_legacy),
    .in_ready  (in_ready),
    .leg_valid (leg_valid),
    .leg_ready (leg_ready),
    .leg_data  (leg_data),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_data  (fwd_data),
    .ovf_err   (ovf_err)
);

// File: tb/legacy_split_reqq_bench.sv
// Bench: behavioural queue model compared with the design on every clock.
module legacy_split_reqq_bench;
    localparam int DW = 16;
    localparam int LS = 2;
    localparam int GD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_legacy = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          leg_valid;
    logic          leg_ready = 1'b0;
    logic [DW-1:0] leg_data;
    logic          fwd_valid;
    logic          fwd_ready = 1'b0;
    logic [DW-1:0] fwd_data;
    logic          ovf_err;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] seq = 16'h0100;

    logic [DW-1:0] legq[$];
    logic [DW-1:0] genq[$];
    bit            ovf_m = 1'b0;

    always #4 clk = ~clk;

    legacy_split_reqq #(.DATA_W(DW), .LEG_SLOTS(LS), .GEN_DEPTH(GD)) u_legacy_split_reqq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_legacy (in_legacy),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .leg_valid (leg_valid),
        .leg_ready (leg_ready),
        .leg_data  (leg_data),
        .fwd_valid (fwd_valid),
        .fwd_ready (fwd_ready),
        .fwd_data  (fwd_data),
        .ovf_err   (ovf_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit v, input bit lg, input bit lr, input bit fr);
        bit    exp_rdy;
        bit    lpop;
        bit    fpop;
        string rtag;
        @(negedge clk);
        seq       = seq + 1'b1;
        in_valid  = v;
        in_legacy = lg;
        in_data   = seq;
        leg_ready = lr;
        fwd_ready = fr;
        #1;
        exp_rdy = lg ? (legq.size() < LS) : (genq.size() < GD);
        rtag    = lg ? "R2" : ((legq.size() == LS) ? "R3" : "R4");
        chk(rtag, "in_ready", DW'(in_ready), DW'(exp_rdy));
        chk("R1", "leg_valid", DW'(leg_valid), DW'(legq.size() != 0));
        if (legq.size() != 0) chk("R5", "leg_data", leg_data, legq[0]);
        chk(lr ? "R1" : "R9", "fwd_valid", DW'(fwd_valid), DW'(genq.size() != 0));
        if (genq.size() != 0) chk("R4/R6", "fwd_data", fwd_data, genq[0]);
        chk("R7", "ovf_err", DW'(ovf_err), DW'(ovf_m));
        lpop = (legq.size() != 0) && lr;
        fpop = (genq.size() != 0) && fr;
        if (v && lg && (legq.size() >= LS)) ovf_m = 1'b1;
        if (lpop) void'(legq.pop_front());
        if (fpop) void'(genq.pop_front());
        if (v && exp_rdy) begin
            if (lg) legq.push_back(seq);
            else    genq.push_back(seq);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        leg_ready = 1'b0;
        fwd_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        legq.delete();
        genq.delete();
        ovf_m = 1'b0;
        #1;
        chk("R8", "leg_valid after reset", DW'(leg_valid), '0);
        chk("R8", "fwd_valid after reset", DW'(fwd_valid), '0);
        chk("R8", "ovf_err after reset", DW'(ovf_err), '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();

        // Legacy side stalled and full; forward stream must keep moving (R3, R9).
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'($urandom_range(0, 1)));
        end
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b1);
        end

        // Random traffic within the agreed legacy limit.
        for (int i = 0; i < 3000; i++) begin
            bit v;
            bit lg;
            v  = 1'($urandom_range(0, 1));
            lg = 1'($urandom_range(0, 1));
            if (lg && (legq.size() >= LS)) v = 1'b0;
            step(v, lg, 1'($urandom_range(0, 3) != 0 ? (i % 64 < 40) : 0),
                 1'($urandom_range(0, 1)));
        end

        // Host exceeds the limit: refused and flagged, then flag stays (R7).
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b1);
        end
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0, 1'b1, 1'b1);
        end

        // Reset clears both buffers and the flag (R8).
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        do_reset();
        step(1'b0, 1'b0, 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule